// File: doc/BRIEF.md
# Bit-masked B-channel serial port

This block is the serial slice that carries the two 8-bit B timeslots of a time-division frame on a shared, open-drain data line. A frame sync marks the first B1 bit; B1 then occupies eight bit times, B2 the next eight, and the remaining bit times up to the next frame sync belong to other channels that this block does not handle. Bits of each channel travel most significant bit first. Bit times are marked by a one-cycle `bit_tick` enable in the system clock domain. On a tick the port samples `rxd` and launches its own bit for that bit time.

A mask per B channel picks which bit positions take part. This lets any single bit position act as its own 8 kbps subchannel for rate adaptation. Received bits in enabled positions are packed into a byte, and the byte is delivered with a one-cycle strobe. In enabled positions the transmitter drives the bit taken from the transmit byte. In every other bit time it releases the line, which then reads as logic one. In concatenated mode both B channels feed one logical stream, and a single 16-bit word comes out per frame.

Sequencer states: `ST_IDLE` (after reset, no frame seen), `ST_B1`, `ST_B2`, `ST_TAIL` (non-B bit times). Transitions: any state to `ST_B1` on a tick with frame sync; `ST_B1` to `ST_B2` after its eighth bit; `ST_B2` to `ST_TAIL` after its eighth bit. `ST_IDLE` and `ST_TAIL` hold until the next frame sync.

Top module: `bchan_mask_port`

## Requirements
- R1: The tick that has `fsync` high is B1 bit position 7. The next seven ticks are B1 positions 6 down to 0, and the eight ticks after those are B2 positions 7 down to 0. Later ticks until the next `fsync` are outside both B channels.
- R2: Only bits in positions whose mask bit is 1 are captured. They are shifted in at the LSB end, so the earliest captured bit ends up highest, and unfilled upper bits are 0.
- R3: In separate mode, `rx_b1_vld` (or `rx_b2_vld`) pulses for one clock in the cycle after the channel's last bit tick, with the packed byte on `rx_b1_data` (`rx_b2_data`). The pulse occurs only if that channel's mask has at least one bit set.
- R4: After a tick in a B bit time whose mask bit is 1, `txd_oe`=1 and `txd_data` equals that position's bit of the transmit byte. After a tick in a masked-off B bit time, `txd_oe`=0 and `txd_data`=1.
- R5: After a tick outside B1 and B2, the line is released (`txd_oe`=0, `txd_data`=1) and no strobe pulses.
- R6: With `concat`=1, the B1 bits and then the B2 bits are packed into one 16-bit `rx_cat_data` word. `rx_cat_vld` pulses once after the last B2 tick if any bit was enabled, and the per-channel strobes stay low.
- R7: With both masks all zero, no strobe is produced and the line is never driven.
- R8: Masks, transmit bytes and `concat` are taken on the frame-sync tick. Changing them later in the frame has no effect until the next frame.
- R9: From reset until the first `fsync` tick, the line is released and no strobe pulses.
- R10: A frame sync arriving before the current frame has finished restarts at B1 bit position 7 and discards partial receive data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bit_tick | input | 1 | One-cycle enable marking a bit time |
| fsync | input | 1 | With `bit_tick`, marks the first B1 bit |
| rxd | input | 1 | Serial receive data, sampled on `bit_tick` |
| concat | input | 1 | 1 = join B1 and B2 into one stream |
| mask_b1 | input | 8 | Enabled bit positions of B1 |
| mask_b2 | input | 8 | Enabled bit positions of B2 |
| tx_b1 | input | 8 | Transmit byte for B1 |
| tx_b2 | input | 8 | Transmit byte for B2 |
| txd_oe | output | 1 | Open-drain drive enable |
| txd_data | output | 1 | Line level: driven bit, or 1 when released |
| rx_b1_data | output | 8 | Packed B1 receive bits |
| rx_b1_vld | output | 1 | One-cycle strobe for `rx_b1_data` |
| rx_b2_data | output | 8 | Packed B2 receive bits |
| rx_b2_vld | output | 1 | One-cycle strobe for `rx_b2_data` |
| rx_cat_data | output | 16 | Packed concatenated receive word |
| rx_cat_vld | output | 1 | One-cycle strobe for `rx_cat_data` |

## Verification
Full masks show the plain MSB-first placement of both channels. A single-bit mask in each channel isolates one 8 kbps subchannel and shows that only that position is driven and captured. A sparse, non-contiguous mask separates correct packing order from positional copying. Concatenated masks that straddle the channel boundary, all-zero masks, masks scrambled mid-frame and an early frame sync then cover joining, silence, frame-start latching and restart.

// File: rtl/bport_pkg.sv
package bport_pkg;
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_B1   = 2'd1,
        ST_B2   = 2'd2,
        ST_TAIL = 2'd3
    } bp_state_t;
endpackage

// File: rtl/bport_seq.sv
// Frame position sequencer: tracks which B channel and bit index each tick is.
module bport_seq
    import bport_pkg::*;
#(
    parameter int B_BITS = 8,
    localparam int CNT_W = (B_BITS > 1) ? $clog2(B_BITS) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             bit_tick,
    input  logic             fsync,
    output bp_state_t        slot_st,
    output logic [CNT_W-1:0] slot_idx,
    output logic             slot_first,
    output logic             slot_last,
    output bp_state_t        state_q
);
    localparam logic [CNT_W-1:0] LAST = CNT_W'(B_BITS - 1);

    bp_state_t        st_q, st_nx;
    logic [CNT_W-1:0] cnt_q, cnt_nx;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q  <= ST_IDLE;
            cnt_q <= '0;
        end else begin
            st_q  <= st_nx;
            cnt_q <= cnt_nx;
        end
    end

    // next state: the slot a tick belongs to
    always_comb begin
        st_nx  = st_q;
        cnt_nx = cnt_q;
        if (bit_tick) begin
            if (fsync) begin
                st_nx  = ST_B1;
                cnt_nx = '0;
            end else begin
                unique case (st_q)
                    ST_IDLE: st_nx = ST_IDLE;
                    ST_B1: begin
                        if (cnt_q == LAST) begin
                            st_nx  = ST_B2;
                            cnt_nx = '0;
                        end else begin
                            cnt_nx = cnt_q + CNT_W'(1);
                        end
                    end
                    ST_B2: begin
                        if (cnt_q == LAST) begin
                            st_nx  = ST_TAIL;
                            cnt_nx = '0;
                        end else begin
                            cnt_nx = cnt_q + CNT_W'(1);
                        end
                    end
                    ST_TAIL: st_nx = ST_TAIL;
                endcase
            end
        end
    end

    // outputs
    always_comb begin
        slot_st    = st_nx;
        slot_idx   = cnt_nx;
        slot_first = (cnt_nx == '0);
        slot_last  = (cnt_nx == LAST);
        state_q    = st_q;
    end

    assert_b2_follows_b1_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == ST_B2 && $past(st_q) != ST_B2) |->
            ($past(st_q) == ST_B1 && $past(cnt_q) == LAST));

    assert_hold_without_tick_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !bit_tick |=> ($stable(st_q) && $stable(cnt_q)));
endmodule

// File: rtl/bport_tx.sv
// Open-drain transmit: drive only enabled B bit positions.
module bport_tx
    import bport_pkg::*;
#(
    parameter int B_BITS = 8,
    localparam int CNT_W = (B_BITS > 1) ? $clog2(B_BITS) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bit_tick,
    input  bp_state_t         slot_st,
    input  logic [CNT_W-1:0]  slot_idx,
    input  logic [B_BITS-1:0] mask1,
    input  logic [B_BITS-1:0] mask2,
    input  logic [B_BITS-1:0] data1,
    input  logic [B_BITS-1:0] data2,
    output logic              oe_q,
    output logic              dat_q
);
    logic [CNT_W-1:0] pos;
    logic             en, bit_v;

    always_comb begin
        pos   = CNT_W'(B_BITS - 1) - slot_idx;
        en    = 1'b0;
        bit_v = 1'b1;
        unique case (slot_st)
            ST_B1: begin
                en    = mask1[pos];
                bit_v = data1[pos];
            end
            ST_B2: begin
                en    = mask2[pos];
                bit_v = data2[pos];
            end
            default: begin
                en    = 1'b0;
                bit_v = 1'b1;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            oe_q  <= 1'b0;
            dat_q <= 1'b1;
        end else if (bit_tick) begin
            oe_q  <= en;
            dat_q <= en ? bit_v : 1'b1;
        end
    end

    assert_released_outside_b_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (bit_tick && (slot_st == ST_TAIL || slot_st == ST_IDLE)) |=> (!oe_q && dat_q));
endmodule

// File: rtl/bport_rx.sv
// Receive packer: shift in enabled bits, strobe per channel or per frame.
module bport_rx
    import bport_pkg::*;
#(
    parameter int B_BITS = 8,
    localparam int CNT_W = (B_BITS > 1) ? $clog2(B_BITS) : 1,
    localparam int W2    = 2 * B_BITS,
    localparam int NW    = $clog2(W2 + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bit_tick,
    input  bp_state_t         slot_st,
    input  logic [CNT_W-1:0]  slot_idx,
    input  logic              slot_first,
    input  logic              slot_last,
    input  logic [B_BITS-1:0] mask1,
    input  logic [B_BITS-1:0] mask2,
    input  logic              cat,
    input  logic              rxd,
    output logic [B_BITS-1:0] b1_data,
    output logic              b1_vld,
    output logic [B_BITS-1:0] b2_data,
    output logic              b2_vld,
    output logic [W2-1:0]     cat_data,
    output logic              cat_vld
);
    logic [W2-1:0]    acc_q, acc_base, acc_nx;
    logic [NW-1:0]    n_q, n_base, n_nx;
    logic [CNT_W-1:0] pos;
    logic             in_b, take, restart;

    always_comb begin
        pos      = CNT_W'(B_BITS - 1) - slot_idx;
        in_b     = (slot_st == ST_B1) || (slot_st == ST_B2);
        take     = bit_tick && ((slot_st == ST_B1 && mask1[pos]) ||
                                (slot_st == ST_B2 && mask2[pos]));
        restart  = slot_first && ((slot_st == ST_B1) || (slot_st == ST_B2 && !cat));
        acc_base = restart ? '0 : acc_q;
        n_base   = restart ? '0 : n_q;
        acc_nx   = take ? {acc_base[W2-2:0], rxd} : acc_base;
        n_nx     = n_base + NW'(take);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            acc_q    <= '0;
            n_q      <= '0;
            b1_data  <= '0;
            b2_data  <= '0;
            cat_data <= '0;
            b1_vld   <= 1'b0;
            b2_vld   <= 1'b0;
            cat_vld  <= 1'b0;
        end else begin
            b1_vld  <= 1'b0;
            b2_vld  <= 1'b0;
            cat_vld <= 1'b0;
            if (bit_tick && in_b) begin
                acc_q <= acc_nx;
                n_q   <= n_nx;
                if (slot_last && n_nx != '0) begin
                    if (slot_st == ST_B1 && !cat) begin
                        b1_data <= acc_nx[B_BITS-1:0];
                        b1_vld  <= 1'b1;
                    end else if (slot_st == ST_B2 && !cat) begin
                        b2_data <= acc_nx[B_BITS-1:0];
                        b2_vld  <= 1'b1;
                    end else if (slot_st == ST_B2 && cat) begin
                        cat_data <= acc_nx;
                        cat_vld  <= 1'b1;
                    end
                end
            end
        end
    end

    assert_single_strobe_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({b1_vld, b2_vld, cat_vld}));

    assert_cat_strobe_mode_R6: assert property (@(posedge clk) disable iff (!rst_n)
        cat_vld |-> $past(cat));

    assert_b1_strobe_timing_R3: assert property (@(posedge clk) disable iff (!rst_n)
        b1_vld |-> $past(bit_tick && slot_st == ST_B1 && slot_last && !cat));

    assert_count_bound_R2: assert property (@(posedge clk) disable iff (!rst_n)
        n_q <= NW'(W2));
endmodule

// File: rtl/bchan_mask_port.sv
// Top: latches frame configuration on frame sync and joins the slices.
module bchan_mask_port
    import bport_pkg::*;
#(
    parameter int B_BITS = 8,
    localparam int CNT_W = (B_BITS > 1) ? $clog2(B_BITS) : 1,
    localparam int W2    = 2 * B_BITS
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bit_tick,
    input  logic              fsync,
    input  logic              rxd,
    input  logic              concat,
    input  logic [B_BITS-1:0] mask_b1,
    input  logic [B_BITS-1:0] mask_b2,
    input  logic [B_BITS-1:0] tx_b1,
    input  logic [B_BITS-1:0] tx_b2,
    output logic              txd_oe,
    output logic              txd_data,
    output logic [B_BITS-1:0] rx_b1_data,
    output logic              rx_b1_vld,
    output logic [B_BITS-1:0] rx_b2_data,
    output logic              rx_b2_vld,
    output logic [W2-1:0]     rx_cat_data,
    output logic              rx_cat_vld
);
    logic [B_BITS-1:0] m1_q, m2_q, t1_q, t2_q;
    logic [B_BITS-1:0] m1_use, m2_use, t1_use, t2_use;
    logic              cat_q, cat_use, frame_start;
    bp_state_t         slot_st, st_q;
    logic [CNT_W-1:0]  slot_idx;
    logic              slot_first, slot_last;

    assign frame_start = bit_tick && fsync;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m1_q  <= '0;
            m2_q  <= '0;
            t1_q  <= '0;
            t2_q  <= '0;
            cat_q <= 1'b0;
        end else if (frame_start) begin
            m1_q  <= mask_b1;
            m2_q  <= mask_b2;
            t1_q  <= tx_b1;
            t2_q  <= tx_b2;
            cat_q <= concat;
        end
    end

    // the frame-sync tick itself uses the fresh inputs
    always_comb begin
        m1_use  = frame_start ? mask_b1 : m1_q;
        m2_use  = frame_start ? mask_b2 : m2_q;
        t1_use  = frame_start ? tx_b1   : t1_q;
        t2_use  = frame_start ? tx_b2   : t2_q;
        cat_use = frame_start ? concat  : cat_q;
    end

    bport_seq #(.B_BITS(B_BITS)) u_seq (
        .clk(clk), .rst_n(rst_n), .bit_tick(bit_tick), .fsync(fsync),
        .slot_st(slot_st), .slot_idx(slot_idx), .slot_first(slot_first),
        .slot_last(slot_last), .state_q(st_q)
    );

    bport_tx #(.B_BITS(B_BITS)) u_tx (
        .clk(clk), .rst_n(rst_n), .bit_tick(bit_tick), .slot_st(slot_st),
        .slot_idx(slot_idx), .mask1(m1_use), .mask2(m2_use),
        .data1(t1_use), .data2(t2_use), .oe_q(txd_oe), .dat_q(txd_data)
    );

    bport_rx #(.B_BITS(B_BITS)) u_rx (
        .clk(clk), .rst_n(rst_n), .bit_tick(bit_tick), .slot_st(slot_st),
        .slot_idx(slot_idx), .slot_first(slot_first), .slot_last(slot_last),
        .mask1(m1_use), .mask2(m2_use), .cat(cat_use), .rxd(rxd),
        .b1_data(rx_b1_data), .b1_vld(rx_b1_vld),
        .b2_data(rx_b2_data), .b2_vld(rx_b2_vld),
        .cat_data(rx_cat_data), .cat_vld(rx_cat_vld)
    );

    assert_zero_mask_quiet_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (bit_tick && !fsync && st_q != ST_IDLE && m1_q == '0 && m2_q == '0)
            |=> (!txd_oe && !rx_b1_vld && !rx_b2_vld && !rx_cat_vld));

    assert_idle_silent_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == ST_IDLE) |-> (!txd_oe && !rx_b1_vld && !rx_b2_vld && !rx_cat_vld));
endmodule

// File: tb/tb_bchan_mask_port.sv
module tb_bchan_mask_port;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bit_tick = 1'b0, fsync = 1'b0, rxd = 1'b1, concat = 1'b0;
    logic [7:0]  mask_b1 = '0, mask_b2 = '0, tx_b1 = '0, tx_b2 = '0;
    logic        txd_oe, txd_data;
    logic [7:0]  rx_b1_data, rx_b2_data;
    logic        rx_b1_vld, rx_b2_vld, rx_cat_vld;
    logic [15:0] rx_cat_data;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 1'b0;

    always #5 clk = ~clk;

    bchan_mask_port dut (
        .clk(clk), .rst_n(rst_n), .bit_tick(bit_tick), .fsync(fsync), .rxd(rxd),
        .concat(concat), .mask_b1(mask_b1), .mask_b2(mask_b2), .tx_b1(tx_b1),
        .tx_b2(tx_b2), .txd_oe(txd_oe), .txd_data(txd_data),
        .rx_b1_data(rx_b1_data), .rx_b1_vld(rx_b1_vld),
        .rx_b2_data(rx_b2_data), .rx_b2_vld(rx_b2_vld),
        .rx_cat_data(rx_cat_data), .rx_cat_vld(rx_cat_vld)
    );

    task automatic chk(input bit ok, input string what, input logic [31:0] act,
                       input logic [31:0] exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", what, act, exp);
        end
    endtask

    // one bit time: drive at negedge, sample at the following negedge
    task automatic tick(input bit fs, input bit r);
        bit_tick = 1'b1;
        fsync    = fs;
        rxd      = r;
        @(posedge clk);
        @(negedge clk);
        bit_tick = 1'b0;
        fsync    = 1'b0;
    endtask

    task automatic run_frame(input string scen, input logic [7:0] m1, input logic [7:0] m2,
                             input logic [7:0] t1, input logic [7:0] t2, input bit cat,
                             input logic [15:0] rxw, input bit scramble);
        logic [15:0] acc = '0;
        int          n = 0;
        mask_b1 = m1; mask_b2 = m2; tx_b1 = t1; tx_b2 = t2; concat = cat;
        for (int i = 0; i < 16; i++) begin
            bit rb, m, t, e_oe, e_d, e1, e2, ec;
            int p;
            rb = rxw[15-i];
            tick(i == 0, rb);
            if (i == 0 && scramble) begin
                mask_b1 = ~m1; mask_b2 = ~m2; tx_b1 = ~t1; tx_b2 = ~t2; concat = !cat;
            end
            p = 7 - (i % 8);
            m = (i < 8) ? m1[p] : m2[p];
            t = (i < 8) ? t1[p] : t2[p];
            e_oe = m;
            e_d  = m ? t : 1'b1;
            chk({txd_oe, txd_data} == {e_oe, e_d},
                $sformatf("R1/R4 line %s bit %0d", scen, i),
                {30'd0, txd_oe, txd_data}, {30'd0, e_oe, e_d});
            if (i == 0 || (i == 8 && !cat)) begin
                acc = '0;
                n   = 0;
            end
            if (m) begin
                acc = {acc[14:0], rb};
                n++;
            end
            e1 = (i == 7  && !cat && n != 0);
            e2 = (i == 15 && !cat && n != 0);
            ec = (i == 15 &&  cat && n != 0);
            chk({rx_b1_vld, rx_b2_vld, rx_cat_vld} == {e1, e2, ec},
                $sformatf("R3/R6/R7 strobes %s bit %0d", scen, i),
                {29'd0, rx_b1_vld, rx_b2_vld, rx_cat_vld}, {29'd0, e1, e2, ec});
            if (e1) chk(rx_b1_data == acc[7:0], {"R2 b1 data ", scen}, rx_b1_data, acc[7:0]);
            if (e2) chk(rx_b2_data == acc[7:0], {"R2 b2 data ", scen}, rx_b2_data, acc[7:0]);
            if (ec) chk(rx_cat_data == acc, {"R6 cat data ", scen}, rx_cat_data, acc);
        end
        for (int i = 0; i < 16; i++) begin
            tick(1'b0, i[0]);
            chk(!txd_oe && txd_data && !rx_b1_vld && !rx_b2_vld && !rx_cat_vld,
                $sformatf("R5 tail %s bit %0d", scen, i),
                {27'd0, txd_oe, txd_data, rx_b1_vld, rx_b2_vld, rx_cat_vld},
                32'h8);
        end
    endtask

    task automatic test_reset_idle();
        chk(!txd_oe && txd_data && !rx_b1_vld && !rx_b2_vld && !rx_cat_vld,
            "R9 reset state", {27'd0, txd_oe, txd_data, rx_b1_vld, rx_b2_vld, rx_cat_vld}, 32'h8);
        mask_b1 = 8'hFF; mask_b2 = 8'hFF; tx_b1 = 8'h00; tx_b2 = 8'h00;
        for (int i = 0; i < 20; i++) begin
            tick(1'b0, 1'b0);
            chk(!txd_oe && !rx_b1_vld && !rx_b2_vld && !rx_cat_vld,
                $sformatf("R9 idle tick %0d", i),
                {28'd0, txd_oe, rx_b1_vld, rx_b2_vld, rx_cat_vld}, 32'h0);
        end
    endtask

    task automatic test_full_mask();
        run_frame("full", 8'hFF, 8'hFF, 8'hA5, 8'h3C, 1'b0, 16'h1234, 1'b0);
    endtask

    task automatic test_single_bit();
        // R2: one position per channel as an 8 kbps subchannel
        run_frame("single1", 8'h10, 8'h01, 8'h00, 8'hFF, 1'b0, 16'h0801, 1'b0);
        run_frame("single0", 8'h10, 8'h01, 8'hFF, 8'h00, 1'b0, 16'hF7FE, 1'b0);
    endtask

    task automatic test_sparse();
        run_frame("sparse", 8'h5A, 8'h81, 8'hC3, 8'h7E, 1'b0, 16'hB66D, 1'b0);
    endtask

    task automatic test_concat();
        // R6: mask straddles channel boundary
        run_frame("concat", 8'h0F, 8'hF0, 8'h96, 8'h69, 1'b1, 16'h5AC3, 1'b0);
        run_frame("concat_b2only", 8'h00, 8'h24, 8'h00, 8'hFF, 1'b1, 16'hFFFF, 1'b0);
    endtask

    task automatic test_zero_mask();
        // R7: both masks zero, then only B1 zero
        run_frame("zero", 8'h00, 8'h00, 8'h00, 8'h00, 1'b0, 16'h0000, 1'b0);
        run_frame("zero_cat", 8'h00, 8'h00, 8'h00, 8'h00, 1'b1, 16'hFFFF, 1'b0);
        run_frame("b1zero", 8'h00, 8'hC0, 8'h00, 8'h40, 1'b0, 16'hFF80, 1'b0);
    endtask

    task automatic test_midframe_change();
        // R8: inputs inverted right after the frame-sync tick
        run_frame("scramble_R8", 8'hA0, 8'h06, 8'h80, 8'h04, 1'b0, 16'h8006, 1'b1);
    endtask

    task automatic test_early_sync();
        // R10: partial frame then a new frame sync
        mask_b1 = 8'hFF; mask_b2 = 8'hFF; concat = 1'b0;
        tick(1'b1, 1'b1);
        for (int i = 0; i < 3; i++) tick(1'b0, 1'b1);
        run_frame("early_R10", 8'hFF, 8'h0F, 8'h55, 8'hAA, 1'b0, 16'h0F0F, 1'b0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        test_reset_idle();
        test_full_mask();
        test_single_bit();
        test_sparse();
        test_concat();
        test_zero_mask();
        test_midframe_change();
        test_early_sync();
        done = 1'b1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (100000) @(posedge clk);
                n_tests++;
                n_fail++;
                $display("FAIL watchdog expired actual=running expected=done");
            end
        join_any
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule